// File: doc/BRIEF.md
# Predictive Hysteresis Current Controller

This block drives the two diagonal switch pairs of a single-phase full-bridge inverter so that the inductor current follows a reference within a hysteresis band. It does not switch on the raw converter sample. It keeps a fixed-point estimate of the inductor current instead. Each rising edge of the slow measurement strobe overwrites the estimate with the measured current. Between two measurements, every rising edge of the fast estimator tick advances the estimate by one slope step. The step is the voltage across the filter inductor times a single gain constant, which holds both the inverse inductance and the tick period. The inductor voltage depends on which pair conducts, on the DC-link voltage and on the estimated grid voltage.

Every change of conducting pair passes through a dead interval of a fixed number of clock cycles, during which both pairs are off. The estimate keeps moving during that interval with a diode-freewheeling slope. The measured current, and not the estimate, is compared with a symmetric overcurrent limit. An excursion past that limit latches a trip that holds both pairs off until reset.

Top module: `phcc_ctrl`

## Requirements
- R1: While reset is asserted, and for DT_CYC clock cycles after its release, both gate outputs, the trip flag and the estimate are 0. On the DT_CYC-th rising edge after release, `gate_pa` (pair A: S1 and S4) rises.
- R2: On a rising edge of `meas_strobe` the estimate becomes `cur_meas * 2^FRAC` on that clock edge. A strobe held high loads only once. `cur_meas` has no effect on the estimate without a strobe edge.
- R3: While pair A conducts, each rising edge of `est_tick` adds floor((vdc_link − vgrid_est) · K_GAIN / 2^KSH) to the estimate.
- R4: While pair B (S2 and S3) conducts, each tick adds floor((−vdc_link − vgrid_est) · K_GAIN / 2^KSH).
- R5: With both pairs off, a tick uses −vdc_link − vgrid_est when the estimate is positive, +vdc_link − vgrid_est when it is negative, and −vgrid_est when it is zero.
- R6: When a measurement strobe edge and a tick edge fall on the same clock, only the load takes effect.
- R7: The estimate saturates at the limits of its EW-bit two's-complement range instead of wrapping.
- R8: While pair A conducts, an estimate strictly above (cur_ref + hyst_band)·2^FRAC turns pair A off on the next clock edge and heads for pair B. Equality keeps pair A on.
- R9: While pair B conducts, an estimate strictly below (cur_ref − hyst_band)·2^FRAC turns pair B off on the next clock edge and heads for pair A. Equality keeps pair B on.
- R10: The two gate outputs are never high together. Each changeover holds both off for exactly DT_CYC clock cycles.
- R11: During the dead interval the estimate is not compared with the band. The pair that follows is the one chosen when the interval began.
- R12: If `cur_meas` is above OC_LIM or below −OC_LIM, `oc_trip` rises on the next clock edge. Both gates drop at once and stay low, and the flag stays high until reset.
- R13: A change of `cur_ref` or `hyst_band` takes effect on the next clock edge without waiting for a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_strobe | input | 1 | Slow measurement strobe, acts on its rising edge |
| est_tick | input | 1 | Fast estimator tick, acts on its rising edge |
| cur_meas | input | IW | Measured inductor current, signed |
| cur_ref | input | IW | Reference current, signed |
| hyst_band | input | IW | Half-width of the hysteresis band, unsigned |
| vgrid_est | input | VW | Estimated grid voltage, signed |
| vdc_link | input | VW | DC-link voltage, unsigned |
| gate_pa | output | 1 | Gate drive of pair A (S1, S4) |
| gate_pb | output | 1 | Gate drive of pair B (S2, S3) |
| oc_trip | output | 1 | Latched overcurrent trip |
| cur_pred | output | IW+FRAC | Current estimate, signed, FRAC fractional bits |

## Verification
The hardest situation to reach from the ports is the dead interval. Only there does the freewheeling slope apply, and only there must out-of-band estimates be ignored. It lasts a few clock cycles and opens only one edge after a band crossing. The stimulus forces a crossing with a measurement load. It then alternates tick and load edges on consecutive clocks inside the window, so that freewheeling is exercised with both signs of the estimate and with a value beyond the opposite band. It also counts the edges so that the arrival of the chosen pair can be checked on its exact cycle.

// File: rtl/phcc_pkg.sv
package phcc_pkg;

  typedef enum logic [2:0] {
    BR_DEAD_P = 3'd0,
    BR_POS    = 3'd1,
    BR_DEAD_N = 3'd2,
    BR_NEG    = 3'd3,
    BR_TRIP   = 3'd4
  } br_state_t;

  typedef enum logic [1:0] {
    SL_RISE = 2'd0,
    SL_FALL = 2'd1,
    SL_GRID = 2'd2
  } slope_sel_t;

  // Inductor voltage polarity for the present bridge state; with both
  // pairs off the diodes conduct against the current direction.
  function automatic slope_sel_t pick_slope(br_state_t st, logic est_pos, logic est_neg);
    slope_sel_t s;
    case (st)
      BR_POS:  s = SL_RISE;
      BR_NEG:  s = SL_FALL;
      default: begin
        if (est_pos)      s = SL_FALL;
        else if (est_neg) s = SL_RISE;
        else              s = SL_GRID;
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/phcc_edge.sv
module phcc_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~q;
  end

endmodule

// File: rtl/phcc_predictor.sv
module phcc_predictor
  import phcc_pkg::*;
#(
  parameter int IW     = 12,
  parameter int VW     = 12,
  parameter int KW     = 18,
  parameter int FRAC   = 8,
  parameter int K_GAIN = 300,
  parameter int KSH    = 8,
  localparam int EW    = IW + FRAC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_ev,
  input  logic                 tick_ev,
  input  logic signed [IW-1:0] meas,
  input  slope_sel_t           sel,
  input  logic        [VW-1:0] vdc,
  input  logic signed [VW-1:0] vg,
  output logic signed [EW-1:0] est
);

  localparam int SVW = VW + 2;
  localparam int PW  = SVW + KW;
  localparam int SW  = ((PW > EW) ? PW : EW) + 1;
  localparam logic signed [KW-1:0] K_S  = KW'(K_GAIN);
  localparam logic signed [SW-1:0] MAXV = {{(SW-EW+1){1'b0}}, {(EW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-EW+1){1'b1}}, {(EW-1){1'b0}}};

  function automatic logic signed [SVW-1:0] drive_volts(
    slope_sel_t s, logic [VW-1:0] dc, logic signed [VW-1:0] g);
    logic signed [SVW-1:0] dc_x, g_x, r;
    dc_x = {2'b00, dc};
    g_x  = {{2{g[VW-1]}}, g};
    case (s)
      SL_RISE: r = dc_x - g_x;
      SL_FALL: r = -dc_x - g_x;
      default: r = -g_x;
    endcase
    return r;
  endfunction

  function automatic logic signed [PW-1:0] scaled_step(logic signed [SVW-1:0] v);
    logic signed [PW-1:0] v_x, k_x, p;
    v_x = {{(PW-SVW){v[SVW-1]}}, v};
    k_x = {{(PW-KW){K_S[KW-1]}}, K_S};
    p   = v_x * k_x;
    return p >>> KSH;
  endfunction

  function automatic logic signed [EW-1:0] clamp_add(
    logic signed [EW-1:0] a, logic signed [PW-1:0] d);
    logic signed [SW-1:0] a_x, d_x, s;
    logic signed [EW-1:0] r;
    a_x = {{(SW-EW){a[EW-1]}}, a};
    d_x = {{(SW-PW){d[PW-1]}}, d};
    s   = a_x + d_x;
    if (s > MAXV)      r = MAXV[EW-1:0];
    else if (s < MINV) r = MINV[EW-1:0];
    else               r = s[EW-1:0];
    return r;
  endfunction

  logic signed [SVW-1:0] volts;
  logic signed [PW-1:0]  delta;
  logic signed [EW-1:0]  est_adv;

  assign volts   = drive_volts(sel, vdc, vg);
  assign delta   = scaled_step(volts);
  assign est_adv = clamp_add(est, delta);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       est <= '0;
    else if (load_ev) est <= {meas, {FRAC{1'b0}}};
    else if (tick_ev) est <= est_adv;
  end

endmodule

// File: rtl/phcc_bridge.sv
module phcc_bridge
  import phcc_pkg::*;
#(
  parameter int IW     = 12,
  parameter int FRAC   = 8,
  parameter int DT_CYC = 8,
  localparam int EW    = IW + FRAC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trip,
  input  logic signed [EW-1:0] est,
  input  logic signed [IW-1:0] cur_ref,
  input  logic        [IW-1:0] band,
  output br_state_t            st,
  output logic                 pair_a,
  output logic                 pair_b,
  output logic                 up_cross,
  output logic                 dn_cross
);

  localparam int CW  = EW + 2;
  localparam int DCW = $clog2(DT_CYC + 1);
  localparam logic [DCW-1:0] DLAST = DCW'(DT_CYC - 1);

  logic signed [IW+1:0] ref_x, band_x, hi_i, lo_i;
  logic signed [CW-1:0] hi_lim, lo_lim, est_x;
  logic        [DCW-1:0] cnt;

  assign ref_x  = {{2{cur_ref[IW-1]}}, cur_ref};
  assign band_x = {2'b00, band};
  assign hi_i   = ref_x + band_x;
  assign lo_i   = ref_x - band_x;
  assign hi_lim = {hi_i, {FRAC{1'b0}}};
  assign lo_lim = {lo_i, {FRAC{1'b0}}};
  assign est_x  = {{2{est[EW-1]}}, est};

  assign up_cross = (st == BR_POS) && (est_x > hi_lim);
  assign dn_cross = (st == BR_NEG) && (est_x < lo_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= BR_DEAD_P;
      cnt <= '0;
    end else if (trip) begin
      st  <= BR_TRIP;
      cnt <= '0;
    end else begin
      case (st)
        BR_POS: if (up_cross) begin
          st  <= BR_DEAD_N;
          cnt <= '0;
        end
        BR_NEG: if (dn_cross) begin
          st  <= BR_DEAD_P;
          cnt <= '0;
        end
        BR_DEAD_P: begin
          if (cnt == DLAST) st <= BR_POS;
          else              cnt <= cnt + DCW'(1);
        end
        BR_DEAD_N: begin
          if (cnt == DLAST) st <= BR_NEG;
          else              cnt <= cnt + DCW'(1);
        end
        default: st <= BR_TRIP;
      endcase
    end
  end

  assign pair_a = (st == BR_POS) && !trip;
  assign pair_b = (st == BR_NEG) && !trip;

endmodule

// File: rtl/phcc_oc_guard.sv
module phcc_oc_guard #(
  parameter int IW     = 12,
  parameter int OC_LIM = 1800
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [IW-1:0] meas,
  output logic                 trip
);

  localparam logic signed [IW-1:0] LIM_P = IW'(OC_LIM);
  localparam logic signed [IW-1:0] LIM_N = IW'(-OC_LIM);

  logic over;
  assign over = (meas > LIM_P) || (meas < LIM_N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    trip <= 1'b0;
    else if (over) trip <= 1'b1;
  end

endmodule

// File: rtl/phcc_ctrl.sv
module phcc_ctrl
  import phcc_pkg::*;
#(
  parameter int IW     = 12,
  parameter int VW     = 12,
  parameter int KW     = 18,
  parameter int FRAC   = 8,
  parameter int K_GAIN = 300,
  parameter int KSH    = 8,
  parameter int DT_CYC = 8,
  parameter int OC_LIM = 1800,
  localparam int EW    = IW + FRAC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 meas_strobe,
  input  logic                 est_tick,
  input  logic signed [IW-1:0] cur_meas,
  input  logic signed [IW-1:0] cur_ref,
  input  logic        [IW-1:0] hyst_band,
  input  logic signed [VW-1:0] vgrid_est,
  input  logic        [VW-1:0] vdc_link,
  output logic                 gate_pa,
  output logic                 gate_pb,
  output logic                 oc_trip,
  output logic signed [EW-1:0] cur_pred
);

  logic [1:0]  strb_rise;
  logic        load_ev, tick_ev;
  logic        up_cross, dn_cross;
  logic        est_pos, est_neg;
  br_state_t   br_st;
  slope_sel_t  sel;

  phcc_edge #(.N(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({meas_strobe, est_tick}),
    .rise (strb_rise)
  );

  assign load_ev = strb_rise[1];
  assign tick_ev = strb_rise[0];

  assign est_neg = cur_pred[EW-1];
  assign est_pos = !cur_pred[EW-1] && (|cur_pred);
  assign sel     = pick_slope(br_st, est_pos, est_neg);

  phcc_predictor #(
    .IW(IW), .VW(VW), .KW(KW), .FRAC(FRAC), .K_GAIN(K_GAIN), .KSH(KSH)
  ) u_pred (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_ev(load_ev),
    .tick_ev(tick_ev),
    .meas   (cur_meas),
    .sel    (sel),
    .vdc    (vdc_link),
    .vg     (vgrid_est),
    .est    (cur_pred)
  );

  phcc_oc_guard #(.IW(IW), .OC_LIM(OC_LIM)) u_oc (
    .clk  (clk),
    .rst_n(rst_n),
    .meas (cur_meas),
    .trip (oc_trip)
  );

  phcc_bridge #(.IW(IW), .FRAC(FRAC), .DT_CYC(DT_CYC)) u_br (
    .clk     (clk),
    .rst_n   (rst_n),
    .trip    (oc_trip),
    .est     (cur_pred),
    .cur_ref (cur_ref),
    .band    (hyst_band),
    .st      (br_st),
    .pair_a  (gate_pa),
    .pair_b  (gate_pb),
    .up_cross(up_cross),
    .dn_cross(dn_cross)
  );

endmodule

// File: rtl/phcc_ctrl_chk.sv
module phcc_ctrl_chk #(
  parameter int IW   = 12,
  parameter int FRAC = 8,
  localparam int EW  = IW + FRAC
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 gate_pa,
  input logic                 gate_pb,
  input logic                 oc_trip,
  input logic signed [IW-1:0] cur_meas,
  input logic signed [EW-1:0] cur_pred,
  input logic                 load_ev,
  input logic                 up_cross,
  input logic                 dn_cross
);

  logic signed [EW-1:0] ld_val;
  assign ld_val = {cur_meas, {FRAC{1'b0}}};

  p_pairs_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_pa && gate_pb));

  p_bbm_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_pa) |-> $past(!gate_pb));

  p_bbm_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_pb) |-> $past(!gate_pa));

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (cur_pred == $past(ld_val)));

  p_trip_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    oc_trip |=> oc_trip);

  p_trip_gates_r12: assert property (@(posedge clk) disable iff (!rst_n)
    oc_trip |-> (!gate_pa && !gate_pb));

  p_up_cross_r8: assert property (@(posedge clk) disable iff (!rst_n)
    up_cross |=> !gate_pa);

  p_dn_cross_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dn_cross |=> !gate_pb);

endmodule

bind phcc_ctrl phcc_ctrl_chk #(.IW(IW), .FRAC(FRAC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .gate_pa (gate_pa),
  .gate_pb (gate_pb),
  .oc_trip (oc_trip),
  .cur_meas(cur_meas),
  .cur_pred(cur_pred),
  .load_ev (load_ev),
  .up_cross(up_cross),
  .dn_cross(dn_cross)
);

// File: tb/phcc_ctrl_tb.sv
module phcc_ctrl_tb;

  localparam int IW = 12, VW = 12, FRAC = 8, EW = IW + FRAC;
  localparam int KG = 300, KS = 8, DT = 8, OCL = 1800;
  localparam longint EMAX = (64'sd1 <<< (EW-1)) - 1;
  localparam longint EMIN = -(64'sd1 <<< (EW-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic meas_strobe = 1'b0, est_tick = 1'b0;
  logic signed [IW-1:0] cur_meas = '0, cur_ref = '0, vgrid_est = '0;
  logic        [IW-1:0] hyst_band = '0;
  logic        [VW-1:0] vdc_link = '0;
  logic gate_pa, gate_pb, oc_trip;
  logic signed [EW-1:0] cur_pred;

  int total = 0, bad = 0;
  longint exp_est;

  always #4 clk = ~clk;

  phcc_ctrl #(.IW(IW), .VW(VW), .FRAC(FRAC), .K_GAIN(KG), .KSH(KS),
              .DT_CYC(DT), .OC_LIM(OCL)) u_dut (
    .clk(clk), .rst_n(rst_n), .meas_strobe(meas_strobe), .est_tick(est_tick),
    .cur_meas(cur_meas), .cur_ref(cur_ref), .hyst_band(hyst_band),
    .vgrid_est(vgrid_est), .vdc_link(vdc_link), .gate_pa(gate_pa),
    .gate_pb(gate_pb), .oc_trip(oc_trip), .cur_pred(cur_pred));

  function automatic longint advance(longint prev, longint volts);
    longint n = prev + ((volts * KG) >>> KS);
    if (n > EMAX) n = EMAX;
    if (n < EMIN) n = EMIN;
    return n;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; meas_strobe = 1'b0; est_tick = 1'b0; cur_meas = '0;
    step(3);
    chk("R1 reset pa", gate_pa, 0);
    chk("R1 reset pb", gate_pb, 0);
    chk("R1 reset trip", oc_trip, 0);
    chk("R1 reset est", cur_pred, 0);
    rst_n = 1'b1;
    exp_est = 0;
  endtask

  task automatic t_reset_r1;
    do_reset;
    step(DT - 1);
    chk("R1 pa low before dead end", gate_pa, 0);
    step(1);
    chk("R1 pa high at dead end", gate_pa, 1);
    chk("R1 pb low", gate_pb, 0);
  endtask

  task automatic t_load_r2_r6;
    cur_ref = 0; hyst_band = 200; vdc_link = 200; vgrid_est = 50;
    cur_meas = 100; meas_strobe = 1'b1;
    step(1);
    chk("R2 load", cur_pred, 100 * 256);
    cur_meas = 120;
    step(2);
    chk("R2 held strobe loads once", cur_pred, 100 * 256);
    meas_strobe = 1'b0;
    step(1);
    cur_meas = -50; meas_strobe = 1'b1; est_tick = 1'b1;
    step(1);
    chk("R6 load beats tick", cur_pred, -50 * 256);
    meas_strobe = 1'b0; est_tick = 1'b0; cur_meas = 900;
    step(2);
    chk("R2 no strobe no load", cur_pred, -50 * 256);
  endtask

  task automatic load(int v);
    cur_meas = v[IW-1:0]; meas_strobe = 1'b1;
    step(1);
    meas_strobe = 1'b0;
    exp_est = longint'(v) * 256;
  endtask

  task automatic tick(longint volts);
    est_tick = 1'b1;
    step(1);
    est_tick = 1'b0;
    exp_est = advance(exp_est, volts);
  endtask

  task automatic t_pos_r3;
    load(0); step(1);
    tick(200 - 50); step(1);
    chk("R3 pair A slope 1", cur_pred, exp_est);
    tick(200 - 50); step(1);
    chk("R3 pair A slope 2", cur_pred, exp_est);
    chk("R3 pair A still on", gate_pa, 1);
  endtask

  task automatic t_switch_dead;
    load(200); step(1);
    chk("R8 equal to upper bound keeps A", gate_pa, 1);
    load(201);
    chk("R8 A on during crossing cycle", gate_pa, 1);
    step(1);
    chk("R8 A off after crossing", gate_pa, 0);
    chk("R10 B off in dead", gate_pb, 0);
    tick(-200 - 50);
    chk("R5 freewheel positive est", cur_pred, exp_est);
    load(-300);
    chk("R11 load below band in dead", cur_pred, exp_est);
    tick(200 - 50);
    chk("R5 freewheel negative est", cur_pred, exp_est);
    load(0);
    step(3);
    chk("R10 both off edge 7 of dead A", gate_pa, 0);
    chk("R10 both off edge 7 of dead B", gate_pb, 0);
    step(1);
    chk("R11 pair B follows despite est", gate_pb, 1);
    step(1);
    tick(-200 - 50); step(1);
    chk("R4 pair B slope", cur_pred, exp_est);
    chk("R4 pair B on", gate_pb, 1);
    load(-200); step(1);
    chk("R9 equal to lower bound keeps B", gate_pb, 1);
    load(-201);
    chk("R9 B on during crossing cycle", gate_pb, 1);
    step(1);
    chk("R9 B off after crossing", gate_pb, 0);
    step(DT - 1);
    chk("R10 A still off", gate_pa, 0);
    step(1);
    chk("R10 A on after dead", gate_pa, 1);
  endtask

  task automatic t_band_r13;
    load(0); step(1);
    chk("R13 A on before band change", gate_pa, 1);
    cur_ref = -1; hyst_band = 0;
    step(1);
    chk("R13 live band change turns A off", gate_pa, 0);
    cur_ref = 0; hyst_band = 200;
  endtask

  task automatic t_sat_r7;
    do_reset;
    vdc_link = 100; vgrid_est = -2000;
    step(DT + 1);
    load(2047); step(1);
    chk("R7 load near top", cur_pred, exp_est);
    tick(-100 + 2000); step(1);
    chk("R7 positive saturation", cur_pred, EMAX);
    chk("R7 check model", exp_est, EMAX);
    vgrid_est = 2000;
    load(-2048); step(1);
    tick(100 - 2000); step(1);
    chk("R7 negative saturation", cur_pred, EMIN);
    chk("R12 gates off after big sample", gate_pa | gate_pb, 0);
  endtask

  task automatic t_oc_r12(int lim_in, int lim_out);
    do_reset;
    step(DT + 1);
    chk("R12 A on before trip", gate_pa, 1);
    cur_meas = lim_in[IW-1:0];
    step(2);
    chk("R12 no trip at limit", oc_trip, 0);
    chk("R12 A on at limit", gate_pa, 1);
    cur_meas = lim_out[IW-1:0];
    step(1);
    chk("R12 trip past limit", oc_trip, 1);
    chk("R12 gates off on trip", gate_pa | gate_pb, 0);
    cur_meas = 0;
    step(12);
    chk("R12 trip latched", oc_trip, 1);
    chk("R12 gates stay off", gate_pa | gate_pb, 0);
    chk("R2 est untouched without strobe", cur_pred, 0);
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_r1;
    t_load_r2_r6;
    t_pos_r3;
    t_switch_dead;
    t_band_r13;
    t_sat_r7;
    t_oc_r12(OCL, OCL + 1);
    t_oc_r12(-OCL, -OCL - 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule